// File: doc/BRIEF.md
# Burst Flash Read Phase Sequencer

This block runs synchronous burst reads from an external flash device. An access starts with a one-cycle start pulse that carries an address, a word count and two hints about the access that follows: whether it targets the same device, and whether it is a read. The sequencer steps through a fixed chain of phases, each timed by a programmable cycle count. The address phase strobes ADV. The address hold phase keeps the address on a multiplexed bus. The command delay phase leaves a gap. The command wait phase asserts RD. A run of burst phases follows, each closing with a data sample. A recovery phase with three timers ends the access.

The block counts the valid samples. In non-continuous mode it re-issues the address at every page boundary. A WAIT mode chooses how a sample taken with WAIT asserted is handled: extend mode drops the sample and runs another burst phase; terminate mode restarts the access at the next 32-word device page. A global multiplier can stretch the phase counts, and a per-phase mask selects which counts it applies to.

States: `ST_IDLE`, `ST_ADDR`, `ST_AHOLD`, `ST_CDLY`, `ST_CWAIT`, `ST_BURST`, `ST_RECOV`. Transitions:
- IDLE to ADDR on an accepted start.
- ADDR to AHOLD, to CDLY or to CWAIT. A phase whose length is zero is skipped.
- AHOLD to CDLY or to CWAIT.
- CDLY to CWAIT.
- CWAIT to BURST.
- BURST back to BURST for the next sample, or for a dropped sample in extend mode.
- BURST to ADDR at a page boundary, or on a terminate-mode restart.
- BURST to RECOV after the last sample when a timer is non-zero, otherwise BURST to IDLE.
- RECOV to IDLE when all three timers expire.

Top module: `bflash_rd_seq`

## Requirements
- R1: A start with a non-zero `start_words` is accepted only in idle, and `busy` is high from the next cycle until recovery completes. A start while `busy` is high, or a start with `start_words` of 0, is ignored and `busy` stays low.
- R2: The address phase always runs, for max(1, its scaled count) cycles. During it `flash_adv_n` is 0, `flash_mux_oe` is 1 and `flash_addr` holds the access address.
- R3: The address hold phase lasts its scaled count, with `flash_mux_oe` high and ADV, RD and BAA inactive. A count of 0 skips it.
- R4: The command delay phase lasts its scaled count, with all controls inactive and `flash_mux_oe` low. A count of 0 skips it.
- R5: The command wait phase drives `flash_rd_n` low for max(1, `cfg_cwait_cyc` × factor) cycles. It is always scaled.
- R6: The factor is `cfg_mult`+1. Each set mask bit applies it to one count: bit 0 the address count, bit 1 the hold count, bit 2 the delay count, bit 3 the burst count and bit 5 the recovery count. Bit 4 has no effect.
- R7: Each burst phase drives `flash_rd_n` and `flash_baa_n` low for max(1, scaled burst count) cycles. Data and WAIT are sampled at the clock edge that closes the phase. An accepted sample appears on `rdata` with `rdata_valid` high in the next cycle.
- R8: Recovery lasts as long as the largest of three timers: the scaled recovery count, `cfg_cs_ta_cyc` × factor and `cfg_rw_ta_cyc` × factor. All controls are inactive during it, and it is skipped when all three are 0.
- R9: The chip-select turnaround timer is 0 when `next_same_dev` was 1 at the start. The read/write turnaround timer is 0 when `next_is_read` was 1.
- R10: When `cfg_continuous` is 0, a new address phase at the next word address begins after every 2^`cfg_page_log2` accepted samples counted since the last address phase, provided words remain.
- R11: When `cfg_wait_term` is 0, a sample taken with `flash_wait` high is dropped and another burst phase follows at the same address.
- R12: When `cfg_wait_term` is 1, a sample taken with `flash_wait` high is dropped. A new address phase then starts at the next 32-word aligned address, with the remaining count unchanged and the page count restarted.
- R13: The access delivers exactly `start_words` samples, in increasing address order from `start_addr`, and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Access request pulse |
| start_addr | input | AW | First word address |
| start_words | input | NW | Number of words to read |
| next_same_dev | input | 1 | Following access targets the same device |
| next_is_read | input | 1 | Following access is a read |
| cfg_mult | input | MW | Multiplier minus one |
| cfg_mult_mask | input | 6 | Per-phase multiplier enables |
| cfg_addr_cyc | input | CW | Address phase count |
| cfg_hold_cyc | input | CW | Address hold count |
| cfg_cdly_cyc | input | CW | Command delay count |
| cfg_cwait_cyc | input | CW | Command wait count |
| cfg_burst_cyc | input | CW | Burst phase count |
| cfg_recov_cyc | input | CW | Recovery count |
| cfg_cs_ta_cyc | input | CW | Chip-select turnaround count |
| cfg_rw_ta_cyc | input | CW | Read/write turnaround count |
| cfg_page_log2 | input | PGW | Log2 of the page length in words |
| cfg_continuous | input | 1 | 1 disables page re-addressing |
| cfg_wait_term | input | 1 | 1 selects terminate mode, 0 extend mode |
| flash_data | input | DW | Read data from the device |
| flash_wait | input | 1 | Device wait, active high |
| flash_addr | output | AW | Current word address |
| flash_mux_oe | output | 1 | Drive address on the multiplexed bus |
| flash_adv_n | output | 1 | Address valid, active low |
| flash_rd_n | output | 1 | Read strobe, active low |
| flash_baa_n | output | 1 | Burst address advance, active low |
| rdata | output | DW | Accepted read word |
| rdata_valid | output | 1 | `rdata` holds a new word |
| busy | output | 1 | Access in progress |

## Verification
A wrong phase count or a lost state shows within the same access. The numbers of cycles with ADV, bus drive, RD and BAA active no longer match the arithmetic totals, and neither does the number of quiet cycles. A broken sample counter or page counter shows as a missing or extra address phase, or as a wrong address when ADV is asserted. A broken data path shows as a wrong word on `rdata` at the next sample. A bad recovery timer changes the length of `busy`. The bench compares each of these quantities for every access in a sweep that covers multipliers, masks, page lengths, both WAIT modes and both turnaround hints.

// File: rtl/bfrs_pkg.sv
package bfrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AHOLD,
        ST_CDLY,
        ST_CWAIT,
        ST_BURST,
        ST_RECOV
    } seq_state_e;

    // index of each phase in the count and length vectors; also its mask bit
    localparam int PH_ADDR  = 0;
    localparam int PH_HOLD  = 1;
    localparam int PH_CDLY  = 2;
    localparam int PH_BURST = 3;
    localparam int PH_CWAIT = 4;
    localparam int PH_RECOV = 5;
    localparam int NUM_PH   = 6;

    // device page size used by the terminate-mode restart
    localparam int DEV_PAGE_LOG2 = 5;

endpackage

// File: rtl/bfrs_phase_len.sv
module bfrs_phase_len
    import bfrs_pkg::*;
#(
    parameter int CW = 4,
    parameter int MW = 3,
    parameter int LW = CW + MW + 1
) (
    input  logic [NUM_PH-1:0][CW-1:0] cnt_all,
    input  logic [NUM_PH-1:0]         mask,
    input  logic [MW:0]               factor,
    output logic [NUM_PH-1:0][LW-1:0] len_all
);

    for (genvar gi = 0; gi < NUM_PH; gi++) begin : g_ph
        // command wait count is scaled whatever its mask bit says
        localparam bit FORCE = (gi == PH_CWAIT);
        logic use_f;
        assign use_f       = FORCE || mask[gi];
        assign len_all[gi] = LW'(cnt_all[gi]) * (use_f ? LW'(factor) : LW'(1));
    end

endmodule

// File: rtl/bfrs_recov.sv
module bfrs_recov #(
    parameter int CW = 4,
    parameter int MW = 3,
    parameter int LW = CW + MW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tick,
    input  logic [LW-1:0] rec_len,
    input  logic [CW-1:0] cs_cyc,
    input  logic [CW-1:0] rw_cyc,
    input  logic [MW:0]   factor,
    input  logic          same_dev,
    input  logic          next_read,
    output logic          need,
    output logic          done
);

    localparam int NT = 3;

    logic [NT-1:0][LW-1:0] tval;
    logic [NT-1:0][LW-1:0] tq;
    logic [NT-1:0]         nz;
    logic [NT-1:0]         le1;

    assign tval[0] = rec_len;
    assign tval[1] = same_dev  ? '0 : LW'(cs_cyc) * LW'(factor);
    assign tval[2] = next_read ? '0 : LW'(rw_cyc) * LW'(factor);

    for (genvar gt = 0; gt < NT; gt++) begin : g_tmr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tq[gt] <= '0;
            end else if (load) begin
                tq[gt] <= tval[gt];
            end else if (tick && tq[gt] != '0) begin
                tq[gt] <= tq[gt] - LW'(1);
            end
        end
        assign nz[gt]  = (tval[gt] != '0);
        assign le1[gt] = (tq[gt] <= LW'(1));
    end

    assign need = |nz;
    assign done = &le1;

endmodule

// File: rtl/bfrs_xfer.sv
module bfrs_xfer
    import bfrs_pkg::*;
#(
    parameter int AW  = 16,
    parameter int NW  = 8,
    parameter int PGW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  load_addr,
    input  logic [NW-1:0]  load_words,
    input  logic           take,
    input  logic           restart,
    input  logic [PGW-1:0] page_log2,
    input  logic           continuous,
    output logic [AW-1:0]  addr,
    output logic           last_word,
    output logic           page_full
);

    localparam int PCW = (1 << PGW) + 1;

    logic [NW-1:0]  rem_q;
    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] page_len;
    logic [AW-1:0]  next_page;

    assign page_len  = PCW'(1) << page_log2;
    assign next_page = {addr[AW-1:DEV_PAGE_LOG2] + 1'b1, {DEV_PAGE_LOG2{1'b0}}};
    assign last_word = (rem_q == NW'(1));
    assign page_full = !continuous && ((pc_q + PCW'(1)) == page_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            rem_q <= '0;
            pc_q  <= '0;
        end else if (load) begin
            addr  <= load_addr;
            rem_q <= load_words;
            pc_q  <= '0;
        end else if (restart) begin
            addr  <= next_page;
            pc_q  <= '0;
        end else if (take) begin
            addr  <= addr + AW'(1);
            rem_q <= rem_q - NW'(1);
            pc_q  <= page_full ? '0 : pc_q + PCW'(1);
        end
    end

endmodule

// File: rtl/bflash_rd_seq.sv
module bflash_rd_seq
    import bfrs_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int NW  = 8,
    parameter int CW  = 4,
    parameter int MW  = 3,
    parameter int PGW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic [NW-1:0]  start_words,
    input  logic           next_same_dev,
    input  logic           next_is_read,
    input  logic [MW-1:0]  cfg_mult,
    input  logic [5:0]     cfg_mult_mask,
    input  logic [CW-1:0]  cfg_addr_cyc,
    input  logic [CW-1:0]  cfg_hold_cyc,
    input  logic [CW-1:0]  cfg_cdly_cyc,
    input  logic [CW-1:0]  cfg_cwait_cyc,
    input  logic [CW-1:0]  cfg_burst_cyc,
    input  logic [CW-1:0]  cfg_recov_cyc,
    input  logic [CW-1:0]  cfg_cs_ta_cyc,
    input  logic [CW-1:0]  cfg_rw_ta_cyc,
    input  logic [PGW-1:0] cfg_page_log2,
    input  logic           cfg_continuous,
    input  logic           cfg_wait_term,
    input  logic [DW-1:0]  flash_data,
    input  logic           flash_wait,
    output logic [AW-1:0]  flash_addr,
    output logic           flash_mux_oe,
    output logic           flash_adv_n,
    output logic           flash_rd_n,
    output logic           flash_baa_n,
    output logic [DW-1:0]  rdata,
    output logic           rdata_valid,
    output logic           busy
);

    localparam int LW = CW + MW + 1;

    seq_state_e state, nstate;

    logic [LW-1:0]               cnt_q;
    logic [LW-1:0]               load_len;
    logic [MW:0]                 factor;
    logic [NUM_PH-1:0][CW-1:0]   cnt_all;
    logic [NUM_PH-1:0][LW-1:0]   len_all;
    logic                        go, phase_end, enter;
    logic                        take, restart, rec_load;
    logic                        rec_need, rec_done;
    logic                        last_word, page_full;
    logic                        same_q, nrd_q;

    assign factor = (MW+1)'(cfg_mult) + (MW+1)'(1);

    assign cnt_all[PH_ADDR]  = cfg_addr_cyc;
    assign cnt_all[PH_HOLD]  = cfg_hold_cyc;
    assign cnt_all[PH_CDLY]  = cfg_cdly_cyc;
    assign cnt_all[PH_BURST] = cfg_burst_cyc;
    assign cnt_all[PH_CWAIT] = cfg_cwait_cyc;
    assign cnt_all[PH_RECOV] = cfg_recov_cyc;

    bfrs_phase_len #(.CW(CW), .MW(MW), .LW(LW)) u_len (
        .cnt_all (cnt_all),
        .mask    (cfg_mult_mask),
        .factor  (factor),
        .len_all (len_all)
    );

    bfrs_xfer #(.AW(AW), .NW(NW), .PGW(PGW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state == ST_IDLE && go),
        .load_addr  (start_addr),
        .load_words (start_words),
        .take       (take),
        .restart    (restart),
        .page_log2  (cfg_page_log2),
        .continuous (cfg_continuous),
        .addr       (flash_addr),
        .last_word  (last_word),
        .page_full  (page_full)
    );

    bfrs_recov #(.CW(CW), .MW(MW), .LW(LW)) u_recov (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rec_load),
        .tick      (state == ST_RECOV),
        .rec_len   (len_all[PH_RECOV]),
        .cs_cyc    (cfg_cs_ta_cyc),
        .rw_cyc    (cfg_rw_ta_cyc),
        .factor    (factor),
        .same_dev  (same_q),
        .next_read (nrd_q),
        .need      (rec_need),
        .done      (rec_done)
    );

    assign go        = start && (start_words != '0);
    assign phase_end = (cnt_q == '0);

    // next state and the per-edge strobes
    always_comb begin
        nstate   = state;
        enter    = 1'b0;
        take     = 1'b0;
        restart  = 1'b0;
        rec_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nstate = ST_ADDR;
                    enter  = 1'b1;
                end
            end
            ST_ADDR: begin
                if (phase_end) begin
                    enter = 1'b1;
                    if (len_all[PH_HOLD] != '0)      nstate = ST_AHOLD;
                    else if (len_all[PH_CDLY] != '0) nstate = ST_CDLY;
                    else                             nstate = ST_CWAIT;
                end
            end
            ST_AHOLD: begin
                if (phase_end) begin
                    enter  = 1'b1;
                    nstate = (len_all[PH_CDLY] != '0) ? ST_CDLY : ST_CWAIT;
                end
            end
            ST_CDLY: begin
                if (phase_end) begin
                    enter  = 1'b1;
                    nstate = ST_CWAIT;
                end
            end
            ST_CWAIT: begin
                if (phase_end) begin
                    enter  = 1'b1;
                    nstate = ST_BURST;
                end
            end
            ST_BURST: begin
                if (phase_end) begin
                    enter = 1'b1;
                    if (flash_wait) begin
                        if (cfg_wait_term) begin
                            restart = 1'b1;
                            nstate  = ST_ADDR;
                        end else begin
                            nstate  = ST_BURST;
                        end
                    end else begin
                        take = 1'b1;
                        if (last_word) begin
                            if (rec_need) begin
                                rec_load = 1'b1;
                                nstate   = ST_RECOV;
                            end else begin
                                nstate   = ST_IDLE;
                            end
                        end else if (page_full) begin
                            nstate = ST_ADDR;
                        end else begin
                            nstate = ST_BURST;
                        end
                    end
                end
            end
            ST_RECOV: begin
                if (rec_done) nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // length of the phase being entered
    always_comb begin
        unique case (nstate)
            ST_ADDR:  load_len = (len_all[PH_ADDR]  == '0) ? LW'(1) : len_all[PH_ADDR];
            ST_AHOLD: load_len = len_all[PH_HOLD];
            ST_CDLY:  load_len = len_all[PH_CDLY];
            ST_CWAIT: load_len = (len_all[PH_CWAIT] == '0) ? LW'(1) : len_all[PH_CWAIT];
            ST_BURST: load_len = (len_all[PH_BURST] == '0) ? LW'(1) : len_all[PH_BURST];
            default:  load_len = LW'(1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // phase counter, access hints and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            same_q      <= 1'b0;
            nrd_q       <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            if (enter)               cnt_q <= load_len - LW'(1);
            else if (cnt_q != '0)    cnt_q <= cnt_q - LW'(1);
            if (state == ST_IDLE && go) begin
                same_q <= next_same_dev;
                nrd_q  <= next_is_read;
            end
            if (take) rdata <= flash_data;
            rdata_valid <= take;
        end
    end

    // outputs decoded from the state
    always_comb begin
        flash_mux_oe = 1'b0;
        flash_adv_n  = 1'b1;
        flash_rd_n   = 1'b1;
        flash_baa_n  = 1'b1;
        busy         = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_ADDR: begin
                flash_adv_n  = 1'b0;
                flash_mux_oe = 1'b1;
            end
            ST_AHOLD: flash_mux_oe = 1'b1;
            ST_CDLY:  ;
            ST_CWAIT: flash_rd_n = 1'b0;
            ST_BURST: begin
                flash_rd_n  = 1'b0;
                flash_baa_n = 1'b0;
            end
            ST_RECOV: ;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/bfrs_chk.sv
module bfrs_chk #(
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NW-1:0] start_words,
    input logic          flash_wait,
    input logic          flash_mux_oe,
    input logic          flash_adv_n,
    input logic          flash_rd_n,
    input logic          flash_baa_n,
    input logic          rdata_valid,
    input logic          busy
);

    assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_words != '0) |=> (busy && !flash_adv_n));

    assert_zero_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_words == '0) |=> !busy);

    assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_adv_n |-> (flash_mux_oe && flash_rd_n && flash_baa_n));

    assert_no_rd_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_mux_oe |-> flash_rd_n);

    assert_rd_opens_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_rd_n) |-> flash_baa_n);

    assert_baa_with_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_baa_n |-> !flash_rd_n);

    assert_valid_after_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(!flash_baa_n && !flash_wait));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_adv_n && flash_rd_n && flash_baa_n && !flash_mux_oe));

endmodule

bind bflash_rd_seq bfrs_chk #(.NW(NW)) u_bfrs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_words  (start_words),
    .flash_wait   (flash_wait),
    .flash_mux_oe (flash_mux_oe),
    .flash_adv_n  (flash_adv_n),
    .flash_rd_n   (flash_rd_n),
    .flash_baa_n  (flash_baa_n),
    .rdata_valid  (rdata_valid),
    .busy         (busy)
);

// File: tb/bflash_rd_seq_bench.sv
module bflash_rd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [7:0]  start_words = '0;
    logic        next_same_dev = 1'b0;
    logic        next_is_read = 1'b0;
    logic [2:0]  cfg_mult = '0;
    logic [5:0]  cfg_mult_mask = '0;
    logic [3:0]  cfg_addr_cyc = '0, cfg_hold_cyc = '0, cfg_cdly_cyc = '0, cfg_cwait_cyc = '0;
    logic [3:0]  cfg_burst_cyc = '0, cfg_recov_cyc = '0, cfg_cs_ta_cyc = '0, cfg_rw_ta_cyc = '0;
    logic [2:0]  cfg_page_log2 = '0;
    logic        cfg_continuous = 1'b0;
    logic        cfg_wait_term = 1'b0;
    logic [15:0] flash_data;
    logic        flash_wait = 1'b0;
    logic [15:0] flash_addr;
    logic        flash_mux_oe, flash_adv_n, flash_rd_n, flash_baa_n;
    logic [15:0] rdata;
    logic        rdata_valid, busy;

    int total = 0;
    int bad = 0;

    logic [15:0] exp_addr [64];
    logic [15:0] exp_data [64];

    always #10 clk = ~clk;

    function automatic logic [15:0] dev_word(input logic [15:0] a);
        return (a * 16'd3) ^ 16'h5A3C;
    endfunction

    assign flash_data = dev_word(flash_addr);

    bflash_rd_seq u_bflash_rd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_words(start_words), .next_same_dev(next_same_dev),
        .next_is_read(next_is_read), .cfg_mult(cfg_mult), .cfg_mult_mask(cfg_mult_mask),
        .cfg_addr_cyc(cfg_addr_cyc), .cfg_hold_cyc(cfg_hold_cyc), .cfg_cdly_cyc(cfg_cdly_cyc),
        .cfg_cwait_cyc(cfg_cwait_cyc), .cfg_burst_cyc(cfg_burst_cyc),
        .cfg_recov_cyc(cfg_recov_cyc), .cfg_cs_ta_cyc(cfg_cs_ta_cyc),
        .cfg_rw_ta_cyc(cfg_rw_ta_cyc), .cfg_page_log2(cfg_page_log2),
        .cfg_continuous(cfg_continuous), .cfg_wait_term(cfg_wait_term),
        .flash_data(flash_data), .flash_wait(flash_wait), .flash_addr(flash_addr),
        .flash_mux_oe(flash_mux_oe), .flash_adv_n(flash_adv_n), .flash_rd_n(flash_rd_n),
        .flash_baa_n(flash_baa_n), .rdata(rdata), .rdata_valid(rdata_valid), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_access(input int i);
        int f, a_len, h_len, d_len, w_len, b_len, r_len, nwords, wmode, page;
        int k, t, rem, pc, ne_a, ne_d, j;
        logic [15:0] ad;
        int cyc, n_adv, n_oe, n_rd, n_baa, n_quiet, n_val, aidx, dm, am, c, it;
        logic prev_adv;

        // configuration picked from the sweep index
        cfg_mult       = (i % 3 == 0) ? 3'd0 : ((i % 3 == 1) ? 3'd2 : 3'd1);
        cfg_mult_mask  = ((i / 3) % 2 == 1) ? 6'h2F : 6'h10;
        cfg_addr_cyc   = 4'((i / 6) % 3);
        cfg_hold_cyc   = 4'((i / 2) % 2);
        cfg_cdly_cyc   = 4'((i / 4) % 3);
        cfg_cwait_cyc  = 4'((i / 12) % 3);
        cfg_burst_cyc  = 4'((i / 5) % 3);
        cfg_recov_cyc  = 4'((i / 7) % 3);
        cfg_cs_ta_cyc  = 4'((i / 11) % 3);
        cfg_rw_ta_cyc  = 4'((i / 13) % 3);
        next_same_dev  = ((i % 2) ^ ((i / 8) % 2)) == 1;
        next_is_read   = ((i / 4) % 2) == 1;
        cfg_page_log2  = 3'((i / 9) % 3);
        cfg_continuous = ((i / 17) % 4) == 0;
        wmode          = (i / 19) % 3;
        cfg_wait_term  = (wmode == 2);
        nwords         = 1 + (i * 7) % 9;
        start_words    = 8'(nwords);
        start_addr     = 16'h0100 + 16'(i * 13);

        // expected phase lengths (R2..R9)
        f     = int'(cfg_mult) + 1;
        a_len = mx(int'(cfg_addr_cyc) * (cfg_mult_mask[0] ? f : 1), 1);
        h_len = int'(cfg_hold_cyc) * (cfg_mult_mask[1] ? f : 1);
        d_len = int'(cfg_cdly_cyc) * (cfg_mult_mask[2] ? f : 1);
        w_len = mx(int'(cfg_cwait_cyc) * f, 1);
        b_len = mx(int'(cfg_burst_cyc) * (cfg_mult_mask[3] ? f : 1), 1);
        r_len = mx(int'(cfg_recov_cyc) * (cfg_mult_mask[5] ? f : 1),
                   mx(next_same_dev ? 0 : int'(cfg_cs_ta_cyc) * f,
                      next_is_read  ? 0 : int'(cfg_rw_ta_cyc) * f));
        page  = 1 << int'(cfg_page_log2);

        // expected sample and address sequence (R10..R13)
        ad = start_addr; rem = nwords; pc = 0; k = 1; t = 0; ne_a = 1; ne_d = 0;
        exp_addr[0] = ad;
        while (rem > 0) begin
            j = t;
            t++;
            if (wmode != 0 && (j % 3 == 1)) begin
                if (wmode == 2) begin
                    ad = {ad[15:5] + 11'd1, 5'd0};
                    pc = 0; k++;
                    exp_addr[ne_a] = ad; ne_a++;
                end
            end else begin
                exp_data[ne_d] = dev_word(ad); ne_d++;
                ad = ad + 16'd1; rem--; pc++;
                if (rem > 0 && !cfg_continuous && pc == page) begin
                    pc = 0; k++;
                    exp_addr[ne_a] = ad; ne_a++;
                end
            end
        end

        // run and observe
        @(negedge clk);
        start = 1'b1;
        cyc = 0; n_adv = 0; n_oe = 0; n_rd = 0; n_baa = 0; n_quiet = 0; n_val = 0;
        aidx = 0; dm = 0; am = 0; c = 0; it = 0; prev_adv = 1'b1;
        forever begin
            @(negedge clk);
            it++;
            start = (it == 2);
            if (it == 2) begin
                start_addr  = 16'h7777;
                start_words = 8'd7;
            end
            if (rdata_valid) begin
                if (n_val >= ne_d || rdata !== exp_data[n_val]) begin
                    dm++;
                    if (n_val < ne_d)
                        $display("FAIL R13 word %0d: actual=%h expected=%h", n_val, rdata, exp_data[n_val]);
                end
                n_val++;
            end
            if (!busy || it > 4000) begin
                flash_wait = 1'b0;
                break;
            end
            cyc++;
            if (!flash_adv_n) n_adv++;
            if (flash_mux_oe) n_oe++;
            if (!flash_rd_n) n_rd++;
            if (!flash_baa_n) n_baa++;
            if (flash_adv_n && flash_rd_n && flash_baa_n && !flash_mux_oe) n_quiet++;
            if (!flash_adv_n && prev_adv) begin
                if (aidx >= ne_a || flash_addr !== exp_addr[aidx]) am++;
                aidx++;
            end
            prev_adv = flash_adv_n;
            if (!flash_baa_n) begin
                flash_wait = (wmode != 0) && (((c / b_len) % 3) == 1);
                c++;
            end else begin
                flash_wait = 1'b0;
            end
        end
        start = 1'b0;

        chk("R6 R8 R9 busy cycles", cyc, k * (a_len + h_len + d_len + w_len) + t * b_len + r_len);
        chk("R2 adv cycles", n_adv, k * a_len);
        chk("R3 bus drive cycles", n_oe, k * (a_len + h_len));
        chk("R4 R8 quiet cycles", n_quiet, k * d_len + r_len);
        chk("R5 rd cycles", n_rd, k * w_len + t * b_len);
        chk("R7 baa cycles", n_baa, t * b_len);
        chk("R13 valid words", n_val, nwords);
        chk("R11 R13 data mismatches", dm, 0);
        chk("R10 address phases", aidx, k);
        chk("R2 R12 address mismatches", am, 0);

        // the start pulse seen while busy must have left no access behind
        repeat (3) @(negedge clk);
        chk("R1 ignored start while busy", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset adv", int'(flash_adv_n), 1);
        chk("R1 reset rd", int'(flash_rd_n), 1);
        chk("R1 reset baa", int'(flash_baa_n), 1);
        chk("R1 reset valid", int'(rdata_valid), 0);

        // zero word count is ignored
        start_words = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 zero words no busy", int'(busy), 0);
        @(negedge clk);
        chk("R1 zero words still idle", int'(busy), 0);

        for (int i = 0; i < 240; i++) run_access(i);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule